// File: doc/BRIEF.md
# DMA Transfer Sequencer

This block steps one direct-memory-access service from request to bus release. While idle it looks at the prioritised peripheral request on every clock. When a request arrives it asks the processor for the bus and waits for the grant. It then walks a fixed four-state transfer: it drives the peripheral acknowledge and the memory and I/O strobes, and it adds wait cycles while the transfer-ready input is low. At the end of the byte it pulses a byte-done signal to the register set. Then, depending on the service mode and on the end conditions, it starts another byte or gives the bus back.

Four service modes are supported: single, block, demand and cascade. A memory-to-memory option replaces the normal transfer with an eight-state read-then-write sequence. Channel registers, address counting and priority selection stay outside the block. The register set supplies a last-count flag, and the block reports termination back to it.

Top module: `dma_xfer_seq`

## Requirements
- R1: While reset is asserted, and at the first clock after it, every output is low.
- R2: In idle, `periph_req_i` is sampled on each clock. `hold_req_o` goes high one cycle after a clock that sees the request high, and stays low otherwise.
- R3: While waiting for the grant, `hold_req_o` is high and `grant_o`, `bus_own_o` and all strobes are low. The cycle after a clock that sees `hold_ack_i` high, `grant_o` and `bus_own_o` go high.
- R4: A peripheral transfer has four states T1..T4. `dir_in_i` = 1 moves data from the peripheral to memory; `dir_in_i` = 0 moves data from memory to the peripheral. In T2 only the read strobe is high (`io_rd_o` for direction 1, `mem_rd_o` for direction 0). In T3 the read strobe and the matching write strobe are both high. In T4 no strobe is high and `byte_done_o` is high.
- R5: If `xfer_rdy_i` is low at the clock ending T3, wait cycles with the T3 strobes repeat until a clock sees it high. T4 follows that clock.
- R6: Single mode (`mode_i` = 00): after T4 the block returns to idle, so `hold_req_o` is low for at least one cycle before the next service.
- R7: Block mode (`mode_i` = 01): after T4 the next T1 follows directly with `hold_req_o` held high, whatever the request, until an end condition.
- R8: Demand mode (`mode_i` = 10): after T4 the next T1 follows if the request is high. If it is low the bus is released without `term_o`.
- R9: If `last_cnt_i` or `end_req_i` is high during the final transfer state, `term_o` is high in that cycle and the block is idle in the next one, in every mode.
- R10: Cascade mode (`mode_i` = 11): after the grant, `hold_req_o` and `grant_o` stay high while the request is high, with `bus_own_o` and all strobes low. The cycle after a clock that sees the request low, all of them are low.
- R11: With `m2m_i` = 1 a transfer takes eight states. `bus_own_o` is high in all of them and `grant_o` in none. `mem_rd_o` is high in states 2 and 3, `mem_wr_o` in states 6 and 7, and `byte_done_o` in state 8. Transfers repeat until an end condition.
- R12: In memory-to-memory transfers, `xfer_rdy_i` low at the clock ending state 3 or state 7 repeats that state's strobes until ready returns.
- R13: Mode, direction and memory-to-memory selection are captured on the clock that leaves idle. Changing them during a service has no effect until the next service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req_i | input | 1 | Request of the selected channel |
| hold_ack_i | input | 1 | Bus grant from the processor |
| xfer_rdy_i | input | 1 | Transfer ready; low inserts wait cycles |
| end_req_i | input | 1 | External end-of-service request |
| last_cnt_i | input | 1 | Byte counter is on its last byte |
| mode_i | input | 2 | 00 single, 01 block, 10 demand, 11 cascade |
| dir_in_i | input | 1 | 1 peripheral to memory, 0 memory to peripheral |
| m2m_i | input | 1 | Memory-to-memory transfer |
| hold_req_o | output | 1 | Bus request to the processor |
| grant_o | output | 1 | Acknowledge to the peripheral |
| bus_own_o | output | 1 | Address/bus drive enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| byte_done_o | output | 1 | One byte finished; step address and count |
| term_o | output | 1 | Service terminated by count or end request |

## Verification
Every output is a decode of the registered state, except `term_o`, which also includes the end inputs of the current cycle. A result therefore shows up in the cycle after the clock that sampled its cause: bus request one cycle after the request, acknowledge one cycle after the grant, `byte_done_o` four cycles after the grant when there are no waits, and one more cycle for each clock that sees ready low. The bench drives inputs just after a rising edge and advances a behavioural step-count model on the rising edge. It compares all nine outputs with the model at each falling edge, so each expected value is taken in exactly the cycle it is due.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SVC_SINGLE  = 2'b00,
    SVC_BLOCK   = 2'b01,
    SVC_DEMAND  = 2'b10,
    SVC_CASCADE = 2'b11
  } svc_mode_e;

  // Peripheral transfer: ST_T1..ST_T4 with ST_TW as ready wait.
  // Memory-to-memory: read ST_R1..ST_R4 (wait ST_RW), write ST_W1..ST_W4 (wait ST_WW).
  typedef enum logic [4:0] {
    ST_IDLE, ST_HOLD, ST_CASC,
    ST_T1, ST_T2, ST_T3, ST_TW, ST_T4,
    ST_R1, ST_R2, ST_R3, ST_RW, ST_R4,
    ST_W1, ST_W2, ST_W3, ST_WW, ST_W4
  } seq_state_e;

  typedef struct packed {
    logic hold_req;
    logic grant;
    logic bus_own;
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic byte_done;
  } bus_ctl_t;

endpackage

// File: rtl/dma_ctl_latch.sv
module dma_ctl_latch
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic [1:0] mode_in,
  input  logic       dir_in,
  input  logic       m2m_in,
  output svc_mode_e  mode_q,
  output logic       dir_q,
  output logic       m2m_q
);

  svc_mode_e mode_d;
  logic      dir_d;
  logic      m2m_d;

  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    m2m_d  = m2m_q;
    if (cap_en) begin
      mode_d = svc_mode_e'(mode_in);
      dir_d  = dir_in;
      m2m_d  = m2m_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SVC_SINGLE;
      dir_q  <= 1'b0;
      m2m_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      m2m_q  <= m2m_d;
    end
  end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       ack_i,
  input  logic       rdy_i,
  input  logic       stop_i,
  input  svc_mode_e  mode_q,
  input  logic       m2m_q,
  output seq_state_e state_o,
  output logic       start_o,
  output logic       term_o
);

  seq_state_e cur, nxt;
  logic       last_state;

  assign last_state = (cur == ST_T4) || (cur == ST_W4);
  assign start_o    = (cur == ST_IDLE) && req_i;
  assign term_o     = last_state && stop_i;
  assign state_o    = cur;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE: if (req_i) nxt = ST_HOLD;
      ST_HOLD: begin
        if (ack_i) begin
          if (mode_q == SVC_CASCADE) nxt = ST_CASC;
          else if (m2m_q)            nxt = ST_R1;
          else                       nxt = ST_T1;
        end
      end
      ST_CASC: if (!req_i) nxt = ST_IDLE;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3:   nxt = rdy_i ? ST_T4 : ST_TW;
      ST_TW:   nxt = rdy_i ? ST_T4 : ST_TW;
      ST_T4: begin
        if (stop_i) nxt = ST_IDLE;
        else begin
          unique case (mode_q)
            SVC_SINGLE:  nxt = ST_IDLE;
            SVC_BLOCK:   nxt = ST_T1;
            SVC_DEMAND:  nxt = req_i ? ST_T1 : ST_IDLE;
            SVC_CASCADE: nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
          endcase
        end
      end
      ST_R1:   nxt = ST_R2;
      ST_R2:   nxt = ST_R3;
      ST_R3:   nxt = rdy_i ? ST_R4 : ST_RW;
      ST_RW:   nxt = rdy_i ? ST_R4 : ST_RW;
      ST_R4:   nxt = ST_W1;
      ST_W1:   nxt = ST_W2;
      ST_W2:   nxt = ST_W3;
      ST_W3:   nxt = rdy_i ? ST_W4 : ST_WW;
      ST_WW:   nxt = rdy_i ? ST_W4 : ST_WW;
      ST_W4:   nxt = stop_i ? ST_IDLE : ST_R1;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= ST_IDLE;
    else        cur <= nxt;
  end

endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
  import dma_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       dir_q,
  output bus_ctl_t   ctl_o
);

  logic rd_phase, rw_phase;

  always_comb begin
    ctl_o    = '0;
    rd_phase = 1'b0;
    rw_phase = 1'b0;
    ctl_o.hold_req = (state_i != ST_IDLE);
    unique case (state_i)
      ST_CASC: ctl_o.grant = 1'b1;
      ST_T1, ST_T4: begin
        ctl_o.grant   = 1'b1;
        ctl_o.bus_own = 1'b1;
      end
      ST_T2: begin
        ctl_o.grant   = 1'b1;
        ctl_o.bus_own = 1'b1;
        rd_phase      = 1'b1;
      end
      ST_T3, ST_TW: begin
        ctl_o.grant   = 1'b1;
        ctl_o.bus_own = 1'b1;
        rd_phase      = 1'b1;
        rw_phase      = 1'b1;
      end
      ST_R1, ST_R4, ST_W1, ST_W4: ctl_o.bus_own = 1'b1;
      ST_R2, ST_R3, ST_RW: begin
        ctl_o.bus_own = 1'b1;
        ctl_o.mem_rd  = 1'b1;
      end
      ST_W2, ST_W3, ST_WW: begin
        ctl_o.bus_own = 1'b1;
        ctl_o.mem_wr  = 1'b1;
      end
      default: ;
    endcase
    if (rd_phase) begin
      if (dir_q) ctl_o.io_rd  = 1'b1;
      else       ctl_o.mem_rd = 1'b1;
    end
    if (rw_phase) begin
      if (dir_q) ctl_o.mem_wr = 1'b1;
      else       ctl_o.io_wr  = 1'b1;
    end
    ctl_o.byte_done = (state_i == ST_T4) || (state_i == ST_W4);
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       periph_req_i,
  input  logic       hold_ack_i,
  input  logic       xfer_rdy_i,
  input  logic       end_req_i,
  input  logic       last_cnt_i,
  input  logic [1:0] mode_i,
  input  logic       dir_in_i,
  input  logic       m2m_i,
  output logic       hold_req_o,
  output logic       grant_o,
  output logic       bus_own_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       io_rd_o,
  output logic       io_wr_o,
  output logic       byte_done_o,
  output logic       term_o
);

  logic       rst_meta_n, rst_core_n;
  svc_mode_e  mode_q;
  logic       dir_q, m2m_q, start, stop;
  seq_state_e state;
  bus_ctl_t   ctl;

  // Asynchronous assertion, two-stage synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  assign stop = last_cnt_i | end_req_i;

  dma_ctl_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cap_en  (start),
    .mode_in (mode_i),
    .dir_in  (dir_in_i),
    .m2m_in  (m2m_i),
    .mode_q  (mode_q),
    .dir_q   (dir_q),
    .m2m_q   (m2m_q)
  );

  dma_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .req_i   (periph_req_i),
    .ack_i   (hold_ack_i),
    .rdy_i   (xfer_rdy_i),
    .stop_i  (stop),
    .mode_q  (mode_q),
    .m2m_q   (m2m_q),
    .state_o (state),
    .start_o (start),
    .term_o  (term_o)
  );

  dma_strobe_dec u_dec (
    .state_i (state),
    .dir_q   (dir_q),
    .ctl_o   (ctl)
  );

  assign hold_req_o  = ctl.hold_req;
  assign grant_o     = ctl.grant;
  assign bus_own_o   = ctl.bus_own;
  assign mem_rd_o    = ctl.mem_rd;
  assign mem_wr_o    = ctl.mem_wr;
  assign io_rd_o     = ctl.io_rd;
  assign io_wr_o     = ctl.io_wr;
  assign byte_done_o = ctl.byte_done;

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic periph_req_i,
  input logic xfer_rdy_i,
  input logic hold_req_o,
  input logic grant_o,
  input logic bus_own_o,
  input logic mem_rd_o,
  input logic mem_wr_o,
  input logic io_rd_o,
  input logic io_wr_o,
  input logic byte_done_o,
  input logic term_o
);

  assert_hold_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req_o) |-> $past(periph_req_i));

  assert_grant_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> hold_req_o);

  assert_mem_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_io_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd_o && io_wr_o));

  assert_done_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |=> !byte_done_o);

  assert_wait_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(io_rd_o && mem_wr_o) && !$past(xfer_rdy_i)) |-> (io_rd_o && mem_wr_o));

  assert_wait_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd_o && io_wr_o) && !$past(xfer_rdy_i)) |-> (mem_rd_o && io_wr_o));

  assert_term_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |=> !hold_req_o);

  assert_strobe_owns_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |-> bus_own_o);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .periph_req_i (periph_req_i),
  .xfer_rdy_i   (xfer_rdy_i),
  .hold_req_o   (hold_req_o),
  .grant_o      (grant_o),
  .bus_own_o    (bus_own_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .io_rd_o      (io_rd_o),
  .io_wr_o      (io_wr_o),
  .byte_done_o  (byte_done_o),
  .term_o       (term_o)
);

// File: tb/dma_xfer_seq_test.sv
`timescale 1ns/1ps
module dma_xfer_seq_test;

  logic clk = 1'b0;
  logic rst_n, periph_req_i, hold_ack_i, xfer_rdy_i, end_req_i, last_cnt_i;
  logic [1:0] mode_i;
  logic dir_in_i, m2m_i;
  logic hold_req_o, grant_o, bus_own_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o;
  logic byte_done_o, term_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dma_xfer_seq uut (.*);

  // Processor side: grant follows request one cycle later.
  always @(posedge clk) begin
    #1;
    hold_ack_i = hold_req_o;
  end

  // Reference model: phase 0 idle, 1 waiting for grant, 2 transferring, 3 cascade.
  int m_ph = 0, m_step = 0, m_mode = 0;
  bit m_dir = 0, m_m2m = 0;

  always @(posedge clk) begin
    int last;
    if (!rst_n) begin
      m_ph = 0; m_step = 0;
    end else begin
      last = m_m2m ? 8 : 4;
      case (m_ph)
        0: if (periph_req_i) begin
             m_ph = 1; m_mode = int'(mode_i); m_dir = dir_in_i; m_m2m = m2m_i;
           end
        1: if (hold_ack_i) begin
             if (m_mode == 3) m_ph = 3;
             else begin m_ph = 2; m_step = 1; end
           end
        3: if (!periph_req_i) m_ph = 0;
        default: begin
          if (m_step == last) begin
            if (last_cnt_i || end_req_i) m_ph = 0;
            else if (m_m2m || m_mode == 1) m_step = 1;
            else if (m_mode == 2 && periph_req_i) m_step = 1;
            else m_ph = 0;
          end else if ((m_step == 3 || m_step == 7) && !xfer_rdy_i) begin
            m_step = m_step;  // ready wait: same step repeats
          end else begin
            m_step = m_step + 1;
          end
        end
      endcase
    end
  end

  task automatic chk(input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit xf, rdp, wrp;
    int last;
    if (rst_n && !finished) begin
      xf   = (m_ph == 2);
      last = m_m2m ? 8 : 4;
      rdp  = xf && !m_m2m && (m_step == 2 || m_step == 3);
      wrp  = xf && !m_m2m && (m_step == 3);
      chk("hold_req", hold_req_o, m_ph != 0);
      chk("grant", grant_o, (m_ph == 3) || (xf && !m_m2m));
      chk("bus_own", bus_own_o, xf);
      chk("mem_rd", mem_rd_o, (rdp && !m_dir) || (xf && m_m2m && (m_step == 2 || m_step == 3)));
      chk("mem_wr", mem_wr_o, (wrp && m_dir) || (xf && m_m2m && (m_step == 6 || m_step == 7)));
      chk("io_rd", io_rd_o, rdp && m_dir);
      chk("io_wr", io_wr_o, wrp && !m_dir);
      chk("byte_done", byte_done_o, xf && m_step == last);
      chk("term", term_o, xf && m_step == last && (last_cnt_i || end_req_i));
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 0; periph_req_i = 0; hold_ack_i = 0; xfer_rdy_i = 1; end_req_i = 0;
    last_cnt_i = 0; mode_i = 2'b00; dir_in_i = 1; m2m_i = 0;
    run(3);
    // R1: all outputs low in reset
    cur_req = "R1";
    chk("reset outputs", |{hold_req_o, grant_o, bus_own_o, mem_rd_o, mem_wr_o,
                           io_rd_o, io_wr_o, byte_done_o, term_o}, 1'b0);
    rst_n = 1;
    run(4);
    // R2: no request keeps idle
    cur_req = "R2"; run(6);
    // R3 R4 R6: single mode, peripheral to memory
    cur_req = "R6"; mode_i = 2'b00; dir_in_i = 1; periph_req_i = 1; run(14);
    periph_req_i = 0; run(8);
    // R4: memory to peripheral
    cur_req = "R4"; dir_in_i = 0; periph_req_i = 1; run(6); periph_req_i = 0; run(8);
    // R5: ready waits
    cur_req = "R5"; dir_in_i = 1; xfer_rdy_i = 0; periph_req_i = 1; run(9);
    xfer_rdy_i = 1; run(2); periph_req_i = 0; dir_in_i = 0; run(1);
    periph_req_i = 1; run(4); xfer_rdy_i = 0; run(2); xfer_rdy_i = 1; periph_req_i = 0; run(10);
    // R7: block mode ignores request until last count
    cur_req = "R7"; mode_i = 2'b01; dir_in_i = 1; periph_req_i = 1; run(2);
    periph_req_i = 0; run(13);
    cur_req = "R9"; last_cnt_i = 1; run(6); last_cnt_i = 0; run(4);
    // R8: demand mode follows request
    cur_req = "R8"; mode_i = 2'b10; periph_req_i = 1; run(13); periph_req_i = 0; run(8);
    // R9: external end in demand mode
    cur_req = "R9"; periph_req_i = 1; run(7); end_req_i = 1; run(3);
    end_req_i = 0; periph_req_i = 0; run(6);
    // R10: cascade handshake only
    cur_req = "R10"; mode_i = 2'b11; periph_req_i = 1; run(9); periph_req_i = 0; run(5);
    // R11: memory to memory
    cur_req = "R11"; mode_i = 2'b00; m2m_i = 1; periph_req_i = 1; run(3);
    periph_req_i = 0; run(20); last_cnt_i = 1; run(10); last_cnt_i = 0; run(3);
    // R12: memory to memory waits in both phases
    cur_req = "R12"; periph_req_i = 1; run(2); periph_req_i = 0;
    for (int i = 0; i < 30; i++) begin
      xfer_rdy_i = (i % 3) != 1;
      run(1);
    end
    xfer_rdy_i = 1; end_req_i = 1; run(10); end_req_i = 0; m2m_i = 0; run(3);
    // R13: captured mode and direction are kept for the whole service
    cur_req = "R13"; mode_i = 2'b01; dir_in_i = 0; periph_req_i = 1; run(3);
    mode_i = 2'b00; dir_in_i = 1; m2m_i = 1; periph_req_i = 0; run(12);
    m2m_i = 0; last_cnt_i = 1; run(6); last_cnt_i = 0; run(4);
    summary();
  end

endmodule